// File: doc/BRIEF.md
# SPI Master with Bypassable Transmit and Receive Queues

This block is a serial-peripheral master that drives clock, data-out and a select line to one slave and collects the slave's reply. Bytes to send are pushed into a transmit queue. Each received byte lands in a receive queue, and the host pops it from there. One 8-bit control register holds the run/stop control and the low-power freeze. It also turns each queue into a single-entry double buffer and flushes either queue. It also sets how many system clocks after each rising serial-clock edge the input line is captured.

Frames are 8 bits, most significant bit first, with the clock idling low and data captured on the rising edge. The serial clock runs at the system clock divided by `DIV` (default 4). A frame starts whenever the transmit queue holds data and the block is neither stopped nor frozen. A stop request that arrives mid-frame lets that frame finish. Misuse of the data ports and receive overruns set sticky flags, which only reset clears.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the control register reads 0x01 (stopped), `cs_n` is 1, `sck` is 0, both queue levels are 0, `rx_empty` is 1 and both error flags are 0.
- R2: Control register layout: bit0 stop, bit1 freeze, bit2 transmit single-buffer, bit3 receive single-buffer, bit4 transmit flush, bit5 receive flush, bits 7:6 capture delay. A write takes effect on the clock edge that accepts it. Read-back shows bits 3:0 and 7:6 as written, bits 5:4 always read 0, and a written delay of 3 (reserved) is stored and read as 0.
- R3: The transmit queue holds up to `DEPTH` (4) bytes. `tx_full` is 1 at capacity. A push while full is dropped, leaves the level unchanged and sets `err_misuse`.
- R4: With the transmit single-buffer bit set, the transmit capacity is one byte.
- R5: With the receive single-buffer bit set, the receive capacity is one byte. A frame that completes while the receive queue is full is discarded and sets `err_overrun`. Both error flags stay set until reset.
- R6: A pop while the receive queue is empty is dropped and sets `err_misuse`.
- R7: Writing 1 to bit4 empties the transmit queue, and writing 1 to bit5 empties the receive queue, both on the write edge. Writing 0 to these bits leaves the levels unchanged.
- R8: Frame timing: `cs_n` falls at the start edge, `sck` rises 2 system clocks later and toggles every `DIV/2` clocks for 16 edges, and `cs_n` rises one clock after the 16th edge. `mosi` carries the byte MSB first and is valid at every rising `sck`. `sck` is 0 whenever `cs_n` is 1.
- R9: With capture delay d (0, 1 or 2), the bit for rising edge n is taken from `miso` d system clocks after the edge that raised `sck`. The delay is latched when the frame starts.
- R10: While the stop bit is set no frame starts. A frame already running completes, and the next one starts after the bit is cleared.
- R11: While the freeze bit is set, the serial engine holds `sck`, `cs_n` and its progress. Clearing the bit resumes the frame where it stopped.
- R12: Received bytes leave the receive queue in arrival order, and `rx_data` always shows the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_level | output | 3 | Bytes held in the transmit queue |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| rx_level | output | 3 | Bytes held in the receive queue |
| err_misuse | output | 1 | Sticky: push to full or pop from empty |
| err_overrun | output | 1 | Sticky: received frame discarded |
| busy | output | 1 | Serial engine in a frame |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
Control writes, pushes and pops take effect on the single edge that accepts them. The bench therefore reads levels, flags and read-back at the falling edge just after that edge. Serial timing is counted from the falling edge that first sees `cs_n` low: `sck` is due high at counts 2 and 3 of every 4, `mosi` is sampled at count 4i+2, and `cs_n` returns high after count 32, so a received byte is checked at the first falling edge with `cs_n` high again. For the capture delay, `miso` is driven as a pattern in the count modulo 4, which makes the received byte all ones only when the programmed delay matches the pattern phase.

// File: rtl/spix_pkg.sv
package spix_pkg;

    localparam int unsigned CFG_W     = 8;
    localparam int unsigned B_HALT    = 0;
    localparam int unsigned B_SLEEP   = 1;
    localparam int unsigned B_TXBYP   = 2;
    localparam int unsigned B_RXBYP   = 3;
    localparam int unsigned B_TXCLR   = 4;
    localparam int unsigned B_RXCLR   = 5;
    localparam int unsigned B_DLY_LO  = 6;

    typedef struct packed {
        logic [1:0] dly;
        logic       rx_byp;
        logic       tx_byp;
        logic       sleep;
        logic       halt;
    } spix_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_FIN  = 2'd2
    } spix_eng_e;

    localparam spix_cfg_t CFG_RESET = '{dly: 2'b00, rx_byp: 1'b0, tx_byp: 1'b0,
                                        sleep: 1'b0, halt: 1'b1};

    // Reserved delay code collapses to the zero-delay setting.
    function automatic logic [1:0] legal_dly(input logic [1:0] raw);
        return (raw == 2'b11) ? 2'b00 : raw;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_view(input spix_cfg_t c);
        return {c.dly, 2'b00, c.rx_byp, c.tx_byp, c.sleep, c.halt};
    endfunction

endpackage

// File: rtl/spix_ctl.sv
module spix_ctl
    import spix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output spix_cfg_t        cfg,
    output logic [CFG_W-1:0] rdata,
    output logic             tx_flush,
    output logic             rx_flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            cfg <= '{dly:    legal_dly(wdata[B_DLY_LO+1:B_DLY_LO]),
                     rx_byp: wdata[B_RXBYP],
                     tx_byp: wdata[B_TXBYP],
                     sleep:  wdata[B_SLEEP],
                     halt:   wdata[B_HALT]};
        end
    end

    assign rdata    = cfg_view(cfg);
    assign tx_flush = we & wdata[B_TXCLR];
    assign rx_flush = we & wdata[B_RXCLR];

endmodule

// File: rtl/spix_fifo.sv
module spix_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          bypass,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_rej,
    output logic          pop_rej
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] cap;
    logic          do_push, do_pop;

    // Single-buffer mode caps occupancy at one entry.
    assign cap      = bypass ? LW'(1) : LW'(DEPTH);
    assign full     = (cnt_q >= cap);
    assign empty    = (cnt_q == '0);
    assign do_push  = push & ~full & ~flush;
    assign do_pop   = pop & ~empty & ~flush;
    assign push_rej = push & full & ~flush;
    assign pop_rej  = pop & empty & ~flush;
    assign head     = mem[rd_q];
    assign level    = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            end
            if (do_pop) begin
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
            end
            cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/spix_shifter.sv
module spix_shifter
    import spix_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DIV    = 4,
    localparam int HALF   = DIV / 2,
    localparam int HW     = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int EW     = $clog2(2 * DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              halt,
    input  logic [1:0]        dly_in,
    input  logic              tx_avail,
    input  logic [DATA_W-1:0] tx_head,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DATA_W - 1);
    localparam logic [HW-1:0] DIV_TOP   = HW'(HALF - 1);

    spix_eng_e         state_q;
    logic [HW-1:0]     div_q;
    logic [EW-1:0]     edge_q;
    logic              sck_q, cs_n_q;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [1:0]        dly_q;
    logic              s1_q, s2_q;
    logic              tick, rise, fall, start, capture;

    assign tick  = (state_q == ENG_RUN) && (div_q == DIV_TOP);
    assign rise  = tick & ~sck_q;
    assign fall  = tick & sck_q;
    assign start = (state_q == ENG_IDLE) && tx_avail && !halt;

    // Capture strobe follows the rising edge by the latched delay.
    always_comb begin
        unique case (dly_q)
            2'd1:    capture = s1_q;
            2'd2:    capture = s2_q;
            default: capture = rise;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            div_q   <= '0;
            edge_q  <= '0;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            tx_sh   <= '0;
            rx_sh   <= '0;
            dly_q   <= '0;
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
        end else if (en) begin
            s1_q <= rise;
            s2_q <= s1_q;
            if (capture) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        tx_sh   <= tx_head;
                        dly_q   <= dly_in;
                        cs_n_q  <= 1'b0;
                        div_q   <= '0;
                        edge_q  <= '0;
                        sck_q   <= 1'b0;
                        state_q <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (tick) begin
                        div_q  <= '0;
                        sck_q  <= ~sck_q;
                        edge_q <= edge_q + EW'(1);
                        if (fall) begin
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                        if (edge_q == LAST_EDGE) begin
                            state_q <= ENG_FIN;
                        end
                    end else begin
                        div_q <= div_q + HW'(1);
                    end
                end
                ENG_FIN: begin
                    cs_n_q  <= 1'b1;
                    state_q <= ENG_IDLE;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign tx_pop  = en & start;
    assign rx_push = en & (state_q == ENG_FIN);
    assign rx_word = rx_sh;
    assign busy    = (state_q != ENG_IDLE);
    assign sck     = sck_q;
    assign cs_n    = cs_n_q;
    assign mosi    = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spix_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 4,
    parameter  int DIV    = 4,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic [LW-1:0]     tx_level,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_full,
    output logic [LW-1:0]     rx_level,
    output logic              err_misuse,
    output logic              err_overrun,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    spix_cfg_t         cfg;
    logic              tx_flush, rx_flush;
    logic              tx_empty, tx_pop, tx_push_rej, tx_pop_rej;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic              rx_push, rx_push_rej, rx_pop_rej;

    spix_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .rdata    (cfg_rdata),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush)
    );

    spix_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .bypass    (cfg.tx_byp),
        .push      (tx_push),
        .push_data (tx_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty),
        .push_rej  (tx_push_rej),
        .pop_rej   (tx_pop_rej)
    );

    spix_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .bypass    (cfg.rx_byp),
        .push      (rx_push),
        .push_data (rx_word),
        .pop       (rx_pop),
        .head      (rx_data),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty),
        .push_rej  (rx_push_rej),
        .pop_rej   (rx_pop_rej)
    );

    spix_shifter #(.DATA_W(DATA_W), .DIV(DIV)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .en       (~cfg.sleep),
        .halt     (cfg.halt),
        .dly_in   (cfg.dly),
        .tx_avail (~tx_empty),
        .tx_head  (tx_head),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .busy     (busy),
        .sck      (sck),
        .mosi     (mosi),
        .miso     (miso),
        .cs_n     (cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_misuse  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (tx_push_rej || tx_pop_rej || rx_pop_rej) begin
                err_misuse <= 1'b1;
            end
            if (rx_push_rej) begin
                err_overrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spix_checker.sv
module spix_checker #(
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [7:0]    cfg_wdata,
    input logic [7:0]    cfg_rdata,
    input logic          tx_push,
    input logic          tx_full,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          sck,
    input logic          cs_n,
    input logic          err_misuse,
    input logic          err_overrun
);

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);                                                     // R8

    AST_HALT_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cfg_rdata[0]) |=> cs_n);                                   // R10

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[1] |=> ($stable(sck) && $stable(cs_n)));                  // R11

    AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[4]) |=> (tx_level == '0));                     // R7

    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[5]) |=> (rx_level == '0));                     // R7

    AST_TX_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LW'(DEPTH));                                            // R3

    AST_FULL_PUSH_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_push && !(cfg_we && cfg_wdata[4])) |=> err_misuse);  // R3

    AST_MISUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_misuse |=> err_misuse);                                         // R6

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_overrun |=> err_overrun);                                       // R5

endmodule

bind spi_xfer_engine spix_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .tx_push     (tx_push),
    .tx_full     (tx_full),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .sck         (sck),
    .cs_n        (cs_n),
    .err_misuse  (err_misuse),
    .err_overrun (err_overrun)
);

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_full;
    logic [2:0] tx_level;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_empty, rx_full;
    logic [2:0] rx_level;
    logic       err_misuse, err_overrun, busy;
    logic       sck, mosi, cs_n;
    logic       miso = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_xfer_engine u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_level(tx_level),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_level(rx_level), .err_misuse(err_misuse), .err_overrun(err_overrun), .busy(busy),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int vecs = 0;
    int bads = 0;

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            bads++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Slave model: count falling system-clock edges since select fell.
    int         k = 0;
    logic       cs_prev = 1'b1;
    int         frames_done = 0;
    logic [7:0] mosi_cap = '0;
    logic [7:0] sl_base = 8'h5A;
    logic [7:0] cur_sl = '0;
    bit         phase_mode = 1'b0;
    int         ph_sel = 0;
    bit         chk_on = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            k = 0;
            cs_prev = 1'b1;
            miso = 1'b0;
        end else begin
            if (!cs_n) begin
                if (cs_prev) begin
                    k = 0;
                    cur_sl = sl_base + 8'(frames_done);
                end else begin
                    k = k + 1;
                end
                if (chk_on && k <= 32)
                    chk("R8 sck phase", int'(sck), int'(((k % 4 == 2) || (k % 4 == 3)) && k < 32));
                if ((k % 4 == 2) && k <= 30) mosi_cap[7 - k / 4] = mosi;
                if (phase_mode) miso = ((k % 4) == (1 + ph_sel));
                else if (k == 0) miso = cur_sl[7];
                else if (k <= 32) miso = cur_sl[7 - (k - 1) / 4];
                else miso = 1'b0;
            end else begin
                if (!cs_prev) begin
                    frames_done++;
                    if (chk_on) chk("R8 select length", k, 32);
                end
                miso = 1'b0;
            end
            cs_prev = cs_n;
        end
    end

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk); tx_push = 1'b1; tx_data = v;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic wait_done(input int target);
        while (frames_done < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_select();
        while (cs_n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bads);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bads++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int fd;
        logic [7:0] exp_b;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 cfg read", int'(cfg_rdata), 8'h01);
        chk("R1 cs_n", int'(cs_n), 1);
        chk("R1 sck", int'(sck), 0);
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 rx_empty", int'(rx_empty), 1);
        chk("R1 errors", int'({err_misuse, err_overrun}), 0);

        // R2 read-back over every write value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vv;
            vv = 8'(v);
            wr_cfg(vv);
            exp_b = {(vv[7:6] == 2'b11) ? 2'b00 : vv[7:6], 2'b00, vv[3:0]};
            chk("R2 cfg read-back", int'(cfg_rdata), int'(exp_b));
        end
        do_reset();

        // R3 transmit capacity and overflow
        for (int i = 0; i < 5; i++) begin
            push(8'(8'h10 + i));
            chk("R3 tx_level", int'(tx_level), (i < 4) ? i + 1 : 4);
            if (i == 3) chk("R3 no error before overflow", int'(err_misuse), 0);
        end
        chk("R3 tx_full", int'(tx_full), 1);
        chk("R3 err_misuse", int'(err_misuse), 1);

        // R7 transmit flush
        wr_cfg(8'h01);
        chk("R7 zero flush bit keeps tx", int'(tx_level), 4);
        wr_cfg(8'h11);
        chk("R7 tx flushed", int'(tx_level), 0);
        chk("R7 flush bit reads 0", int'(cfg_rdata), 8'h01);
        do_reset();

        // R8 / R12 sweep over all transmit bytes
        wr_cfg(8'h00);
        sl_base = 8'h5A;
        for (int i = 0; i < 256; i++) begin
            fd = frames_done;
            push(8'(i));
            wait_done(fd + 1);
            chk("R8 mosi byte", int'(mosi_cap), i);
            chk("R12 rx_level", int'(rx_level), 1);
            chk("R12 rx_data", int'(rx_data), int'(8'(sl_base + 8'(fd))));
            pop();
            chk("R12 rx drained", int'(rx_level), 0);
        end
        chk("R8 no error flags", int'({err_misuse, err_overrun}), 0);

        // R12 ordering with full queues, R7 receive flush
        wr_cfg(8'h01);
        for (int i = 0; i < 4; i++) push(8'(8'hC0 + i));
        fd = frames_done;
        wr_cfg(8'h00);
        wait_done(fd + 4);
        chk("R12 rx_level four", int'(rx_level), 4);
        wr_cfg(8'h00);
        chk("R7 zero flush bit keeps rx", int'(rx_level), 4);
        for (int j = 0; j < 2; j++) begin
            chk("R12 order", int'(rx_data), int'(8'(sl_base + 8'(fd + j))));
            pop();
        end
        wr_cfg(8'h20);
        chk("R7 rx flushed", int'(rx_level), 0);
        chk("R7 rx_empty", int'(rx_empty), 1);

        // R6 pop from empty
        pop();
        chk("R6 err_misuse", int'(err_misuse), 1);
        chk("R6 rx_level", int'(rx_level), 0);
        do_reset();

        // R9 capture delay sweep, including the reserved code
        phase_mode = 1'b1;
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 3; p++) begin
                ph_sel = p;
                wr_cfg(8'(d << 6));
                fd = frames_done;
                push(8'h00);
                wait_done(fd + 1);
                chk("R9 delayed capture", int'(rx_data), (((d == 3) ? 0 : d) == p) ? 255 : 0);
                pop();
            end
        end
        phase_mode = 1'b0;
        do_reset();

        // R4 transmit single buffer
        wr_cfg(8'h05);
        push(8'h01);
        chk("R4 level one", int'(tx_level), 1);
        chk("R4 full at one", int'(tx_full), 1);
        chk("R4 no error yet", int'(err_misuse), 0);
        push(8'h02);
        chk("R4 level stays one", int'(tx_level), 1);
        chk("R4 err_misuse", int'(err_misuse), 1);
        wr_cfg(8'h01);
        chk("R4 queue mode not full", int'(tx_full), 0);
        push(8'h03);
        chk("R4 queue mode level", int'(tx_level), 2);
        do_reset();

        // R5 receive single buffer and overrun
        wr_cfg(8'h08);
        fd = frames_done;
        push(8'hA1);
        push(8'hA2);
        wait_done(fd + 2);
        chk("R5 rx_level one", int'(rx_level), 1);
        chk("R5 rx_full", int'(rx_full), 1);
        chk("R5 first byte kept", int'(rx_data), int'(8'(sl_base + 8'(fd))));
        chk("R5 err_overrun", int'(err_overrun), 1);
        chk("R5 no misuse", int'(err_misuse), 0);
        idle(5);
        chk("R5 overrun sticky", int'(err_overrun), 1);
        do_reset();

        // R10 stop during a frame
        push(8'h11);
        push(8'h22);
        fd = frames_done;
        idle(40);
        chk("R10 no start while stopped", frames_done, fd);
        chk("R10 tx held", int'(tx_level), 2);
        wr_cfg(8'h00);
        wait_select();
        wr_cfg(8'h01);
        wait_done(fd + 1);
        idle(60);
        chk("R10 one frame only", frames_done, fd + 1);
        chk("R10 one byte left", int'(tx_level), 1);
        chk("R10 select idle", int'(cs_n), 1);
        wr_cfg(8'h00);
        wait_done(fd + 2);
        chk("R10 resumed", int'(tx_level), 0);
        do_reset();

        // R11 freeze mid-frame
        chk_on = 1'b0;
        wr_cfg(8'h00);
        fd = frames_done;
        push(8'h3C);
        wait_select();
        idle(9);
        wr_cfg(8'h02);
        begin
            logic s0, c0;
            s0 = sck;
            c0 = cs_n;
            idle(20);
            chk("R11 sck frozen", int'(sck), int'(s0));
            chk("R11 cs_n frozen", int'(cs_n), int'(c0));
            chk("R11 no frame end", frames_done, fd);
        end
        wr_cfg(8'h00);
        wait_done(fd + 1);
        chk("R11 frame completes", int'(rx_level), 1);
        chk_on = 1'b1;

        finish_run();
    end

endmodule